// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that finishes every instruction in one clock period. It fetches from an instruction memory array of its own and reads and writes a data memory array of its own. Its datapath holds a 32-entry register file, an ALU, a main decoder and an ALU-function decoder.

The instruction set is a small load/store subset:
- register-register arithmetic and logic;
- add-immediate;
- word load and store;
- branch-if-equal;
- direct jump and jump-with-link;
- a load whose address is the sum of two registers;
- an indirect jump that takes its target from a data-memory word.

A user fills both memory arrays through hierarchical writes and pulses the reset. The core then runs. Each clock it shows the fetch address and the write-back and store it performs in that clock.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0, and no register or memory write is reported. The first instruction after reset is fetched from byte address 0.
- R2: Opcode 0 with funct 32/34/36/37/39/42 writes R[rd] with add, subtract, AND, OR, NOR or signed set-less-than of R[rs] and R[rt]. The shift-amount field, bits [10:6], must be zero.
- R3: Opcode 8 writes R[rt] with R[rs] plus the sign-extended 16-bit immediate in bits [15:0].
- R4: Opcode 35 loads R[rt] from the word at R[rs]+sext(imm). Opcode 43 stores R[rt] to that word at the clock edge, so a load in the next clock sees it. The data-memory word index is address bits [9:2] (default depth), and the upper bits wrap.
- R5: Opcode 4, when R[rs]==R[rt], sets the PC to PC+4+(sext(imm)<<2). Otherwise the PC becomes PC+4. Negative offsets are allowed.
- R6: Opcode 2 sets the PC to {(PC+4)[31:28], bits [25:0], 2'b00}.
- R7: Opcode 3 writes PC+4 into register 31 and jumps like opcode 2.
- R8: Opcode 0 with funct 1 loads R[rd] from the word at R[rs]+R[rt].
- R9: Opcode 62 loads the PC with the data word at R[rs]+sext(imm). It writes no register and no memory.
- R10: Register 0 reads as zero. An instruction that targets it reports no write and changes nothing.
- R11: An unknown opcode, an unknown funct, or a non-zero shift-amount field on opcode 0 writes nothing and advances the PC by 4.
- R12: Every instruction completes in one clock. Its register write is visible to the next instruction, and a non-control instruction advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Byte address of the instruction executing this clock |
| wb_en_o | output | 1 | A register write takes effect at the next edge |
| wb_idx_o | output | 5 | Destination register of that write |
| wb_data_o | output | 32 | Value written |
| st_en_o | output | 1 | A data-memory store takes effect at the next edge |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Word stored |

## Verification
The write-back and store outputs describe the current instruction combinationally, in the same clock in which `pc_o` shows its address. The register file, the data memory and the PC commit at the following rising edge, so the effect of an instruction shows one clock later in `pc_o` and in the operands of the next instruction. The bench samples every output on the falling edge. It compares them with a behavioural model stepped once per falling edge, and it checks the PC against the model's next-PC from the previous step. After reset is asserted, the PC is checked only from the second falling edge on, once a rising edge has captured the reset.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_J     = 6'd2;
  localparam logic [5:0] OP_JAL   = 6'd3;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;
  localparam logic [5:0] OP_JMEM  = 6'd62;

  localparam logic [5:0] FN_LDX = 6'd1;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_NOR = 6'd39;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLT} alu_fn_e;
  typedef enum logic [1:0] {AOP_ADD = 2'd0, AOP_SUB = 2'd1, AOP_FUNCT = 2'd2} alu_op_e;
  typedef enum logic [1:0] {DST_RT = 2'd0, DST_RD = 2'd1, DST_LINK = 2'd2} dst_sel_e;
  typedef enum logic [1:0] {WB_ALU = 2'd0, WB_MEM = 2'd1, WB_PC4 = 2'd2} wb_sel_e;
  typedef enum logic [1:0] {NX_SEQ = 2'd0, NX_JUMP = 2'd1, NX_MEM = 2'd2} nxt_sel_e;

  typedef struct packed {
    dst_sel_e dst;
    wb_sel_e  wb;
    logic     alu_src;
    logic     reg_write;
    logic     mem_read;
    logic     mem_write;
    logic     branch;
    nxt_sel_e nxt;
    alu_op_e  alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int WORDS = 256,
  parameter int W     = 32,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (fn)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_NOR: y = ~(a | b);
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic [4:0] shamt,
  output ctrl_t      ctrl,
  output alu_fn_e    alu_fn
);
  // main decoder
  always_comb begin
    ctrl = '{dst: DST_RT, wb: WB_ALU, alu_src: 1'b0, reg_write: 1'b0,
             mem_read: 1'b0, mem_write: 1'b0, branch: 1'b0,
             nxt: NX_SEQ, alu_op: AOP_ADD};
    unique case (opcode)
      OP_RTYPE: begin
        if (shamt == 5'd0) begin
          unique case (funct)
            FN_ADD, FN_SUB, FN_AND, FN_OR, FN_NOR, FN_SLT: begin
              ctrl.dst       = DST_RD;
              ctrl.reg_write = 1'b1;
              ctrl.alu_op    = AOP_FUNCT;
            end
            FN_LDX: begin
              ctrl.dst       = DST_RD;
              ctrl.wb        = WB_MEM;
              ctrl.reg_write = 1'b1;
              ctrl.mem_read  = 1'b1;
              ctrl.alu_op    = AOP_ADD;
            end
            default: ;
          endcase
        end
      end
      OP_ADDI: begin
        ctrl.alu_src   = 1'b1;
        ctrl.reg_write = 1'b1;
      end
      OP_LW: begin
        ctrl.alu_src   = 1'b1;
        ctrl.wb        = WB_MEM;
        ctrl.reg_write = 1'b1;
        ctrl.mem_read  = 1'b1;
      end
      OP_SW: begin
        ctrl.alu_src   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = AOP_SUB;
      end
      OP_J: ctrl.nxt = NX_JUMP;
      OP_JAL: begin
        ctrl.nxt       = NX_JUMP;
        ctrl.dst       = DST_LINK;
        ctrl.wb        = WB_PC4;
        ctrl.reg_write = 1'b1;
      end
      OP_JMEM: begin
        ctrl.alu_src  = 1'b1;
        ctrl.mem_read = 1'b1;
        ctrl.nxt      = NX_MEM;
      end
      default: ;
    endcase
  end

  // ALU function decoder
  always_comb begin
    unique case (ctrl.alu_op)
      AOP_SUB: alu_fn = ALU_SUB;
      AOP_FUNCT: begin
        unique case (funct)
          FN_SUB:  alu_fn = ALU_SUB;
          FN_AND:  alu_fn = ALU_AND;
          FN_OR:   alu_fn = ALU_OR;
          FN_NOR:  alu_fn = ALU_NOR;
          FN_SLT:  alu_fn = ALU_SLT;
          default: alu_fn = ALU_ADD;
        endcase
      end
      default: alu_fn = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int NREG       = 32,
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 256,
  localparam int IIDX = $clog2(IMEM_WORDS),
  localparam int DIDX = $clog2(DMEM_WORDS),
  localparam int RAW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] pc_o,
  output logic            wb_en_o,
  output logic [RAW-1:0]  wb_idx_o,
  output logic [XLEN-1:0] wb_data_o,
  output logic            st_en_o,
  output logic [XLEN-1:0] st_addr_o,
  output logic [XLEN-1:0] st_data_o
);
  logic [XLEN-1:0] pc, pc4, pc_next, br_target, jmp_target, imm_sext;
  logic [31:0]     instr;
  logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, dm_rdata, ld_data;
  logic            alu_zero;
  ctrl_t           ctrl;
  alu_fn_e         alu_fn;
  logic [RAW-1:0]  dst_idx;

  // fetch
  sc_mem #(.WORDS(IMEM_WORDS), .W(32)) u_imem (
    .clk(clk), .we(1'b0), .idx(pc[IIDX+1:2]), .wdata(32'd0), .rdata(instr)
  );

  sc_ctrl u_ctrl (
    .opcode(instr[31:26]), .funct(instr[5:0]), .shamt(instr[10:6]),
    .ctrl(ctrl), .alu_fn(alu_fn)
  );

  sc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk(clk), .rst(rst), .we(wb_en_o), .waddr(dst_idx), .wdata(wb_data_o),
    .raddr_a(instr[25:21]), .raddr_b(instr[20:16]),
    .rdata_a(rs_val), .rdata_b(rt_val)
  );

  assign imm_sext = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign alu_b    = ctrl.alu_src ? imm_sext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a(rs_val), .b(alu_b), .fn(alu_fn), .y(alu_y), .zero(alu_zero)
  );

  sc_mem #(.WORDS(DMEM_WORDS), .W(XLEN)) u_dmem (
    .clk(clk), .we(st_en_o), .idx(alu_y[DIDX+1:2]), .wdata(rt_val), .rdata(dm_rdata)
  );
  assign ld_data = ctrl.mem_read ? dm_rdata : '0;

  // destination and write-back selection
  always_comb begin
    unique case (ctrl.dst)
      DST_RD:   dst_idx = instr[15:11];
      DST_LINK: dst_idx = RAW'(NREG - 1);
      default:  dst_idx = instr[20:16];
    endcase
  end

  always_comb begin
    unique case (ctrl.wb)
      WB_MEM:  wb_data_o = ld_data;
      WB_PC4:  wb_data_o = pc4;
      default: wb_data_o = alu_y;
    endcase
  end

  assign wb_en_o   = ctrl.reg_write && !rst && (dst_idx != '0);
  assign wb_idx_o  = dst_idx;
  assign st_en_o   = ctrl.mem_write && !rst;
  assign st_addr_o = alu_y;
  assign st_data_o = rt_val;

  // next PC
  assign pc4        = pc + XLEN'(4);
  assign br_target  = pc4 + {imm_sext[XLEN-3:0], 2'b00};
  assign jmp_target = {pc4[XLEN-1:XLEN-4], instr[25:0], 2'b00};

  always_comb begin
    unique case (ctrl.nxt)
      NX_JUMP: pc_next = jmp_target;
      NX_MEM:  pc_next = ld_data;
      default: pc_next = (ctrl.branch && alu_zero) ? br_target : pc4;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign pc_o = pc;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr,
  input logic [31:0] pc_o,
  input logic        wb_en_o,
  input logic [4:0]  wb_idx_o,
  input logic [31:0] wb_data_o,
  input logic        st_en_o
);
  logic [5:0] op;
  logic       op_unknown;
  assign op = instr[31:26];
  always_comb begin
    unique case (op)
      6'd0, 6'd2, 6'd3, 6'd4, 6'd8, 6'd35, 6'd43, 6'd62: op_unknown = 1'b0;
      default: op_unknown = 1'b1;
    endcase
  end

  assert_reset_pc_R1: assert property (@(posedge clk) rst |=> pc_o == 32'd0);

  assert_link_write_R7: assert property (@(posedge clk) disable iff (rst)
    op == 6'd3 |-> wb_en_o && wb_idx_o == 5'd31 && wb_data_o == pc_o + 32'd4);

  assert_store_only_R4: assert property (@(posedge clk) disable iff (rst)
    op == 6'd43 |-> st_en_o && !wb_en_o);

  assert_indirect_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    op == 6'd62 |-> !wb_en_o && !st_en_o);

  assert_unknown_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    op_unknown |-> !wb_en_o && !st_en_o);

  assert_unknown_advance_R11: assert property (@(posedge clk) disable iff (rst)
    op_unknown |=> pc_o == $past(pc_o) + 32'd4);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .rst(rst), .instr(instr), .pc_o(pc_o), .wb_en_o(wb_en_o),
  .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o), .st_en_o(st_en_o)
);

// File: tb/sc_core_test.sv
module sc_core_test;
  localparam int IW = 256;
  localparam int DW = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] pc_o, wb_data_o, st_addr_o, st_data_o;
  logic [4:0]  wb_idx_o;
  logic        wb_en_o, st_en_o;

  sc_core uut (
    .clk(clk), .rst(rst), .pc_o(pc_o), .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o),
    .wb_data_o(wb_data_o), .st_en_o(st_en_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
  );

  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] m_rf [32];
  logic [31:0] m_dm [DW];
  logic [31:0] m_im [IW];
  logic [31:0] m_pc;
  string       pc_tag;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at pc=%h: actual=%h expected=%h", tag, what, m_pc, act, exp);
    end
  endtask

  function automatic logic [31:0] rtyp(input int rs, input int rt, input int rd, input int sh, input int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
  endfunction
  function automatic logic [31:0] ityp(input int op, input int rs, input int rt, input int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] jtyp(input int op, input int word);
    return {op[5:0], word[25:0]};
  endfunction

  // one model step: compare this clock's outputs, then commit
  task automatic model_step();
    logic [31:0] ins, a, b, imm, e_wdata, npc, addr;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, e_widx;
    logic        e_wen, e_st;
    string       tag;
    chk(pc_tag, "pc", pc_o, m_pc);
    ins = m_im[m_pc[9:2]];
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; fn = ins[5:0];
    a = (rs == 0) ? 32'd0 : m_rf[rs];
    b = (rt == 0) ? 32'd0 : m_rf[rt];
    imm = {{16{ins[15]}}, ins[15:0]};
    e_wen = 1'b0; e_widx = 5'd0; e_wdata = 32'd0; e_st = 1'b0; addr = 32'd0;
    npc = m_pc + 32'd4; tag = "R11";
    case (op)
      6'd0: begin
        if (ins[10:6] == 5'd0) begin
          e_widx = rd; tag = "R2"; e_wen = 1'b1;
          case (fn)
            6'd32: e_wdata = a + b;
            6'd34: e_wdata = a - b;
            6'd36: e_wdata = a & b;
            6'd37: e_wdata = a | b;
            6'd39: e_wdata = ~(a | b);
            6'd42: e_wdata = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            6'd1:  begin e_wdata = m_dm[(a + b) >> 2 & (DW - 1)]; tag = "R8"; end
            default: begin e_wen = 1'b0; tag = "R11"; end
          endcase
        end
      end
      6'd8:  begin e_wen = 1'b1; e_widx = rt; e_wdata = a + imm; tag = "R3"; end
      6'd35: begin e_wen = 1'b1; e_widx = rt; e_wdata = m_dm[(a + imm) >> 2 & (DW - 1)]; tag = "R4"; end
      6'd43: begin e_st = 1'b1; addr = a + imm; tag = "R4"; end
      6'd4:  begin tag = "R5"; if (a == b) npc = m_pc + 32'd4 + (imm << 2); end
      6'd2:  begin tag = "R6"; npc = {npc[31:28], ins[25:0], 2'b00}; end
      6'd3:  begin
        tag = "R7"; e_wen = 1'b1; e_widx = 5'd31; e_wdata = m_pc + 32'd4;
        npc = {npc[31:28], ins[25:0], 2'b00};
      end
      6'd62: begin tag = "R9"; npc = m_dm[(a + imm) >> 2 & (DW - 1)]; end
      default: ;
    endcase
    if (e_wen && e_widx == 5'd0) begin e_wen = 1'b0; tag = "R10"; end
    chk(tag, "wb_en", {31'd0, wb_en_o}, {31'd0, e_wen});
    if (e_wen) begin
      chk(tag, "wb_idx", {27'd0, wb_idx_o}, {27'd0, e_widx});
      chk(tag, "wb_data", wb_data_o, e_wdata);
    end
    chk(tag, "st_en", {31'd0, st_en_o}, {31'd0, e_st});
    if (e_st) begin
      chk(tag, "st_addr", st_addr_o, addr);
      chk(tag, "st_data", st_data_o, b);
    end
    if (e_wen) m_rf[e_widx] = e_wdata;
    if (e_st) m_dm[addr[9:2]] = b;
    pc_tag = (tag == "R2" || tag == "R3" || tag == "R4" || tag == "R8" || tag == "R10") ? "R12" : tag;
    m_pc = npc;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "pc in reset", pc_o, 32'd0);
    chk("R1", "wb_en in reset", {31'd0, wb_en_o}, 32'd0);
    chk("R1", "st_en in reset", {31'd0, st_en_o}, 32'd0);
    @(posedge clk);
    #1 rst = 1'b0;
    m_pc = 32'd0;
    pc_tag = "R1";
    for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_step();
    end
  endtask

  initial begin
    for (int i = 0; i < IW; i++) m_im[i] = 32'd0;
    for (int i = 0; i < DW; i++) m_dm[i] = 32'd0;
    m_im[0]  = ityp(8, 0, 1, 5);
    m_im[1]  = ityp(8, 0, 2, -3);
    m_im[2]  = rtyp(1, 2, 3, 0, 32);
    m_im[3]  = rtyp(2, 1, 4, 0, 34);
    m_im[4]  = rtyp(1, 2, 5, 0, 36);
    m_im[5]  = rtyp(1, 2, 6, 0, 37);
    m_im[6]  = rtyp(1, 2, 7, 0, 39);
    m_im[7]  = rtyp(2, 1, 8, 0, 42);
    m_im[8]  = rtyp(1, 2, 9, 0, 42);
    m_im[9]  = ityp(8, 0, 0, 7);
    m_im[10] = rtyp(0, 0, 10, 0, 32);
    m_im[11] = ityp(43, 0, 1, 32);
    m_im[12] = ityp(35, 0, 11, 32);
    m_im[13] = ityp(8, 0, 12, 40);
    m_im[14] = rtyp(12, 0, 13, 0, 1);
    m_im[15] = ityp(4, 1, 2, 5);
    m_im[16] = ityp(4, 1, 1, 1);
    m_im[17] = ityp(8, 0, 14, 99);
    m_im[18] = jtyp(3, 22);
    m_im[19] = ityp(8, 0, 15, 1);
    m_im[22] = ityp(17, 1, 1, 1);
    m_im[23] = rtyp(1, 2, 16, 0, 63);
    m_im[24] = rtyp(1, 2, 17, 3, 32);
    m_im[25] = jtyp(2, 27);
    m_im[26] = ityp(8, 0, 18, 1);
    m_im[27] = ityp(62, 0, 0, 16);
    m_im[28] = ityp(4, 0, 0, -1);
    m_dm[4]  = 32'h0000_0070;
    m_dm[8]  = 32'hFFFF_FFF0;
    m_dm[10] = 32'd1234;
    for (int i = 0; i < IW; i++) uut.u_imem.mem[i] = m_im[i];
    for (int i = 0; i < DW; i++) uut.u_dmem.mem[i] = m_dm[i];

    do_reset();
    run(40);
    do_reset();
    run(40);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule